// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block is the mode-control state machine of a CAN controller. Software drives it through a control word that holds two bits: a reset request and a halt request. The block tracks five modes: re-initialisation, reset (configuration), bus integration, normal operation and halt. It reports the mode it is in through a reset-status flag, a halt-status flag, an on-bus indication and a shared mode-change interrupt flag.

From the protocol side it takes the sampled receive bit, a one-cycle bit-time strobe, a bus-idle indication and a flag that says the baud configuration is valid. It holds the configuration word and the transmit-request and transmit-cancel bit sets as software-visible state. It clears them on re-initialisation. It also ignores transmit writes while a halt is pending.

Leaving reset or halt always passes through integration. In integration the block waits for a run of consecutive recessive bits, counted on the bit strobe, before it declares itself on the bus.

Top module: `can_mode_seq`

## Requirements
- R1: After hardware reset, rst_req_o=1, rst_stat_o=1, halt_req_o=0, halt_stat_o=0, mode_irq_o=0, on_bus_o=0, cfg_o=CFG_DEFAULT, and tx_pend_o and tx_cancel_o are all zero.
- R2: A control write with ctl_rst_req=1 while rst_req_o=0 clears rst_stat_o and halt_req_o on the next edge. It also returns cfg_o, tx_pend_o and tx_cancel_o to their defaults. Exactly INIT_CYCLES cycles later, rst_stat_o and mode_irq_o are set.
- R3: A cfg_we write updates cfg_o only while the block is in reset mode (rst_req_o=1 and rst_stat_o=1). At any other time it is ignored.
- R4: A control write with ctl_rst_req=0 in reset mode clears rst_req_o and starts integration. on_bus_o rises one cycle after the strobe edge that completes JOIN_BITS consecutive recessive (rx_bit=1) bits. At that point rst_stat_o falls.
- R5: A strobed dominant bit (rx_bit=0) during integration restarts the count from zero. The run counter never exceeds JOIN_BITS.
- R6: Joining the bus, entering halt and leaving halt happen only on cycles where baud_ok=1. Otherwise the mode holds.
- R7: With halt_req_o=1 in normal operation, halt is entered only on a cycle with bus_idle=1. Entry sets halt_stat_o and mode_irq_o and clears on_bus_o.
- R8: While a halt is pending (halt_req_o=1, halt_stat_o=0), control writes with ctl_halt_req=0 leave halt_req_o at 1.
- R9: Outside a pending halt, tx_req_we and tx_cancel_we OR their bits into tx_pend_o and tx_cancel_o. While a halt is pending, both writes are ignored.
- R10: A reset-request rising write takes priority over a pending halt. halt_req_o is cleared and re-initialisation starts.
- R11: Writing irq_clr=1 clears mode_irq_o. A mode-change event in the same cycle wins and leaves it set.
- R12: Clearing halt_req_o while in halt moves the block, once baud_ok=1, into integration, with halt_stat_o cleared. It returns to on_bus_o=1 after JOIN_BITS recessive bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_rst_req | input | 1 | Reset-request bit of the control write |
| ctl_halt_req | input | 1 | Halt-request bit of the control write |
| irq_clr | input | 1 | Write-1-to-clear of the mode-change interrupt flag |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| tx_req_we | input | 1 | Transmit-request set strobe |
| tx_req_bits | input | MB | Transmit-request bits to set |
| tx_cancel_we | input | 1 | Transmit-cancel set strobe |
| tx_cancel_bits | input | MB | Transmit-cancel bits to set |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| baud_ok | input | 1 | Baud configuration is valid |
| bus_idle | input | 1 | Protocol engine reports the bus idle |
| rst_req_o | output | 1 | Reset-request bit readback |
| halt_req_o | output | 1 | Halt-request bit readback |
| rst_stat_o | output | 1 | Reset-mode status flag |
| halt_stat_o | output | 1 | Halt-mode status flag |
| mode_irq_o | output | 1 | Mode-change interrupt flag |
| on_bus_o | output | 1 | Normal operation on the bus |
| cfg_o | output | CFG_W | Configuration word |
| tx_pend_o | output | MB | Transmit-request bits |
| tx_cancel_o | output | MB | Transmit-cancel bits |

## Verification
The bench builds the block with MB=4, CFG_W=8, CFG_DEFAULT=8'hA5, INIT_CYCLES=3 and JOIN_BITS=11. The short re-initialisation keeps each reset round trip to a few cycles. This leaves room for the full eleven-bit integration run after reset and again after halt, including a run broken by a dominant bit one short of the target. The non-zero configuration default makes the restore on re-initialisation visible at cfg_o. Four mailbox bits are enough to see partial OR-in and a blocked write during a pending halt.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [2:0] {
        MODE_RESET  = 3'd0,
        MODE_INIT   = 3'd1,
        MODE_INTEG  = 3'd2,
        MODE_NORMAL = 3'd3,
        MODE_HALT   = 3'd4
    } mode_e;

endpackage

// File: rtl/can_init_timer.sv
module can_init_timer #(
    parameter int INIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int TW = (INIT_CYCLES < 2) ? 1 : $clog2(INIT_CYCLES);

    typedef struct packed {
        logic          run;
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.run && (tmr_q.cnt == '0);
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = TW'(INIT_CYCLES - 1);
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == '0) tmr_d.run = 1'b0;
            else                 tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // done only ever fires while the timer runs and is at its last count (R2)
    assert_done_terminal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !tmr_q.run || $past(start));

endmodule

// File: rtl/can_recessive_cnt.sv
module can_recessive_cnt #(
    parameter int JOIN_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic strobe,
    input  logic rx_bit,
    output logic full
);
    localparam int CW = $clog2(JOIN_BITS + 1);
    localparam logic [CW-1:0] TOP = CW'(JOIN_BITS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (strobe) begin
            if (!rx_bit)         cnt_d = '0;
            else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_cnt_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    assert_dominant_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !rx_bit) |=> (cnt_q == '0));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_mode_pkg::*;
#(
    parameter int               MB          = 4,
    parameter int               CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_DEFAULT = '0,
    parameter int               INIT_CYCLES = 4,
    parameter int               JOIN_BITS   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_rst_req,
    input  logic             ctl_halt_req,
    input  logic             irq_clr,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tx_req_we,
    input  logic [MB-1:0]    tx_req_bits,
    input  logic             tx_cancel_we,
    input  logic [MB-1:0]    tx_cancel_bits,
    input  logic             rx_bit,
    input  logic             bit_strobe,
    input  logic             baud_ok,
    input  logic             bus_idle,
    output logic             rst_req_o,
    output logic             halt_req_o,
    output logic             rst_stat_o,
    output logic             halt_stat_o,
    output logic             mode_irq_o,
    output logic             on_bus_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic [MB-1:0]    tx_pend_o,
    output logic [MB-1:0]    tx_cancel_o
);

    typedef struct packed {
        mode_e            mode;
        logic             rst_req;
        logic             halt_req;
        logic             rst_stat;
        logic             halt_stat;
        logic             irq;
        logic [CFG_W-1:0] cfg;
        logic [MB-1:0]    txp;
        logic [MB-1:0]    txc;
    } seq_t;

    seq_t st_d, st_q;

    logic halt_pend, rst_rise, irq_set, tmr_start, tmr_done, run_full;

    can_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    can_recessive_cnt #(.JOIN_BITS(JOIN_BITS)) u_run_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (st_q.mode != MODE_INTEG),
        .strobe (bit_strobe),
        .rx_bit (rx_bit),
        .full   (run_full)
    );

    assign halt_pend = st_q.halt_req && (st_q.mode != MODE_HALT);
    assign rst_rise  = ctl_we && ctl_rst_req && !st_q.rst_req;

    always_comb begin
        st_d      = st_q;
        irq_set   = 1'b0;
        tmr_start = 1'b0;
        if (rst_rise) begin
            st_d.mode      = MODE_INIT;
            st_d.rst_req   = 1'b1;
            st_d.halt_req  = 1'b0;
            st_d.rst_stat  = 1'b0;
            st_d.halt_stat = 1'b0;
            st_d.cfg       = CFG_DEFAULT;
            st_d.txp       = '0;
            st_d.txc       = '0;
            tmr_start      = 1'b1;
        end else begin
            if (ctl_we) begin
                if (!halt_pend) st_d.halt_req = ctl_halt_req;
                if (!ctl_rst_req && st_q.mode == MODE_RESET) begin
                    st_d.rst_req = 1'b0;
                    st_d.mode    = MODE_INTEG;
                end
            end
            if (!halt_pend) begin
                if (tx_req_we)    st_d.txp = st_q.txp | tx_req_bits;
                if (tx_cancel_we) st_d.txc = st_q.txc | tx_cancel_bits;
            end
            if (cfg_we && st_q.mode == MODE_RESET) st_d.cfg = cfg_wdata;
            case (st_q.mode)
                MODE_INIT: if (tmr_done) begin
                    st_d.mode     = MODE_RESET;
                    st_d.rst_stat = 1'b1;
                    irq_set       = 1'b1;
                end
                MODE_INTEG: if (run_full && baud_ok) begin
                    st_d.mode     = MODE_NORMAL;
                    st_d.rst_stat = 1'b0;
                end
                MODE_NORMAL: if (st_q.halt_req && bus_idle && baud_ok) begin
                    st_d.mode      = MODE_HALT;
                    st_d.halt_stat = 1'b1;
                    irq_set        = 1'b1;
                end
                MODE_HALT: if (!st_q.halt_req && baud_ok) begin
                    st_d.mode      = MODE_INTEG;
                    st_d.halt_stat = 1'b0;
                end
                default: ;
            endcase
        end
        if (irq_set)      st_d.irq = 1'b1;
        else if (irq_clr) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_RESET;
            st_q.rst_req  <= 1'b1;
            st_q.rst_stat <= 1'b1;
            st_q.cfg      <= CFG_DEFAULT;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req_o   = st_q.rst_req;
    assign halt_req_o  = st_q.halt_req;
    assign rst_stat_o  = st_q.rst_stat;
    assign halt_stat_o = st_q.halt_stat;
    assign mode_irq_o  = st_q.irq;
    assign on_bus_o    = (st_q.mode == MODE_NORMAL);
    assign cfg_o       = st_q.cfg;
    assign tx_pend_o   = st_q.txp;
    assign tx_cancel_o = st_q.txc;

    assert_join_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_bus_o) |-> $past(run_full && baud_ok));

    assert_halt_exit_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_stat_o) |-> $past(baud_ok || rst_rise));

    assert_halt_entry_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_stat_o) |-> $past(baud_ok && bus_idle && halt_req_o));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o && !halt_stat_o && !rst_rise) |=> halt_req_o);

    assert_tx_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req_o && !halt_stat_o && !rst_rise) |=> ($stable(tx_pend_o) && $stable(tx_cancel_o)));

    assert_reset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_rise |=> (!halt_req_o && !rst_stat_o && rst_req_o));

    assert_irq_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_irq_o) |-> ($rose(rst_stat_o) || $rose(halt_stat_o)));

endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;

    localparam int MB = 4;
    localparam int CFG_W = 8;
    localparam logic [CFG_W-1:0] CFG_DEF = 8'hA5;
    localparam int INIT_CYC = 3;
    localparam int JOIN = 11;

    localparam int M_RST = 0, M_INIT = 1, M_INTEG = 2, M_NORM = 3, M_HALT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 0, ctl_rst_req = 0, ctl_halt_req = 0, irq_clr = 0, cfg_we = 0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic tx_req_we = 0, tx_cancel_we = 0;
    logic [MB-1:0] tx_req_bits = '0, tx_cancel_bits = '0;
    logic rx_bit = 1, bit_strobe = 0, baud_ok = 1, bus_idle = 0;
    logic rst_req_o, halt_req_o, rst_stat_o, halt_stat_o, mode_irq_o, on_bus_o;
    logic [CFG_W-1:0] cfg_o;
    logic [MB-1:0] tx_pend_o, tx_cancel_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    can_mode_seq #(.MB(MB), .CFG_W(CFG_W), .CFG_DEFAULT(CFG_DEF),
                   .INIT_CYCLES(INIT_CYC), .JOIN_BITS(JOIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_rst_req(ctl_rst_req),
        .ctl_halt_req(ctl_halt_req), .irq_clr(irq_clr), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .tx_req_we(tx_req_we), .tx_req_bits(tx_req_bits),
        .tx_cancel_we(tx_cancel_we), .tx_cancel_bits(tx_cancel_bits),
        .rx_bit(rx_bit), .bit_strobe(bit_strobe), .baud_ok(baud_ok),
        .bus_idle(bus_idle), .rst_req_o(rst_req_o), .halt_req_o(halt_req_o),
        .rst_stat_o(rst_stat_o), .halt_stat_o(halt_stat_o),
        .mode_irq_o(mode_irq_o), .on_bus_o(on_bus_o), .cfg_o(cfg_o),
        .tx_pend_o(tx_pend_o), .tx_cancel_o(tx_cancel_o));

    // behavioural reference model
    int m_mode, m_timer, m_run;
    bit m_rreq, m_hreq, m_rstat, m_hstat, m_irq;
    logic [CFG_W-1:0] m_cfg;
    logic [MB-1:0] m_txp, m_txc;
    int o_mode, o_run;
    bit o_hreq, pend, evt;

    task automatic model_reset();
        m_mode = M_RST; m_timer = 0; m_run = 0;
        m_rreq = 1; m_hreq = 0; m_rstat = 1; m_hstat = 0; m_irq = 0;
        m_cfg = CFG_DEF; m_txp = '0; m_txc = '0;
    endtask

    initial model_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            o_mode = m_mode; o_run = m_run; o_hreq = m_hreq;
            pend = m_hreq && (m_mode != M_HALT);
            evt = 0;
            if (ctl_we && ctl_rst_req && !m_rreq) begin
                m_mode = M_INIT; m_timer = INIT_CYC; m_rreq = 1; m_hreq = 0;
                m_rstat = 0; m_hstat = 0; m_cfg = CFG_DEF; m_txp = '0; m_txc = '0;
            end else begin
                if (ctl_we) begin
                    if (!pend) m_hreq = ctl_halt_req;
                    if (!ctl_rst_req && o_mode == M_RST) begin m_rreq = 0; m_mode = M_INTEG; end
                end
                if (!pend && tx_req_we) m_txp = m_txp | tx_req_bits;
                if (!pend && tx_cancel_we) m_txc = m_txc | tx_cancel_bits;
                if (cfg_we && o_mode == M_RST) m_cfg = cfg_wdata;
                if (o_mode == M_INIT) begin
                    m_timer = m_timer - 1;
                    if (m_timer == 0) begin m_mode = M_RST; m_rstat = 1; evt = 1; end
                end else if (o_mode == M_INTEG) begin
                    if (o_run == JOIN && baud_ok) begin m_mode = M_NORM; m_rstat = 0; end
                end else if (o_mode == M_NORM) begin
                    if (o_hreq && bus_idle && baud_ok) begin m_mode = M_HALT; m_hstat = 1; evt = 1; end
                end else if (o_mode == M_HALT) begin
                    if (!o_hreq && baud_ok) begin m_mode = M_INTEG; m_hstat = 0; end
                end
            end
            if (o_mode != M_INTEG) m_run = 0;
            else if (bit_strobe) m_run = rx_bit ? ((m_run < JOIN) ? m_run + 1 : m_run) : 0;
            if (evt) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2 rst_stat", 32'(rst_stat_o), 32'(m_rstat));
            check("R4 rst_req", 32'(rst_req_o), 32'(m_rreq));
            check("R4 on_bus", 32'(on_bus_o), 32'(m_mode == M_NORM));
            check("R3 cfg", 32'(cfg_o), 32'(m_cfg));
            check("R7 halt_stat", 32'(halt_stat_o), 32'(m_hstat));
            check("R8 halt_req", 32'(halt_req_o), 32'(m_hreq));
            check("R9 tx_pend", 32'(tx_pend_o), 32'(m_txp));
            check("R9 tx_cancel", 32'(tx_cancel_o), 32'(m_txc));
            check("R11 irq", 32'(mode_irq_o), 32'(m_irq));
        end
    end

    task automatic write_ctl(bit r, bit h);
        @(negedge clk); ctl_we = 1; ctl_rst_req = r; ctl_halt_req = h;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic send_bit(bit v);
        @(negedge clk); rx_bit = v; bit_strobe = 1;
        @(negedge clk); bit_strobe = 0;
    endtask

    task automatic send_run(int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 power-on state
        check("R1 rst_req", 32'(rst_req_o), 1);
        check("R1 rst_stat", 32'(rst_stat_o), 1);
        check("R1 irq", 32'(mode_irq_o), 0);
        check("R1 cfg", 32'(cfg_o), 32'(CFG_DEF));
        check("R1 on_bus", 32'(on_bus_o), 0);
        rst_n = 1;
        @(negedge clk);
        // R3 config write accepted in reset mode
        cfg_we = 1; cfg_wdata = 8'h3C; @(negedge clk); cfg_we = 0;
        check("R3 cfg in reset", 32'(cfg_o), 32'h3C);
        // R6 leave reset with baud invalid
        baud_ok = 0;
        write_ctl(0, 0);
        send_run(JOIN + 2);
        @(negedge clk);
        check("R6 no join without baud", 32'(on_bus_o), 0);
        baud_ok = 1; @(negedge clk);
        check("R4 join once baud valid", 32'(on_bus_o), 1);
        check("R4 rst_stat cleared", 32'(rst_stat_o), 0);
        // R5 dominant restart: reset, then broken run
        write_ctl(1, 0);
        repeat (INIT_CYC + 1) @(negedge clk);
        check("R2 reset done", 32'(rst_stat_o), 1);
        check("R2 cfg restored", 32'(cfg_o), 32'(CFG_DEF));
        irq_clr = 1; @(negedge clk); irq_clr = 0;
        check("R11 irq cleared", 32'(mode_irq_o), 0);
        write_ctl(0, 0);
        send_run(JOIN - 1); send_bit(0); send_run(JOIN - 1);
        @(negedge clk);
        check("R5 broken run no join", 32'(on_bus_o), 0);
        send_bit(1); @(negedge clk);
        check("R5 join after full run", 32'(on_bus_o), 1);
        // R3 config write ignored on the bus
        cfg_we = 1; cfg_wdata = 8'h11; @(negedge clk); cfg_we = 0;
        check("R3 cfg ignored", 32'(cfg_o), 32'(CFG_DEF));
        // R9 tx writes
        tx_req_we = 1; tx_req_bits = 4'b0101; @(negedge clk); tx_req_we = 0;
        tx_cancel_we = 1; tx_cancel_bits = 4'b0001; @(negedge clk); tx_cancel_we = 0;
        check("R9 tx or-in", 32'(tx_pend_o), 32'h5);
        // halt pending, bus busy
        bus_idle = 0;
        write_ctl(0, 1);
        write_ctl(0, 0);
        check("R8 halt sticky", 32'(halt_req_o), 1);
        tx_req_we = 1; tx_req_bits = 4'b1010; @(negedge clk); tx_req_we = 0;
        check("R9 tx ignored while pending", 32'(tx_pend_o), 32'h5);
        check("R7 no halt on busy bus", 32'(halt_stat_o), 0);
        bus_idle = 1; @(negedge clk);
        check("R7 halt entered", 32'(halt_stat_o), 1);
        check("R7 irq on halt", 32'(mode_irq_o), 1);
        bus_idle = 0;
        // R12 leave halt
        baud_ok = 0;
        write_ctl(0, 0);
        repeat (3) @(negedge clk);
        check("R6 halt held without baud", 32'(halt_stat_o), 1);
        baud_ok = 1; @(negedge clk);
        check("R12 halt left", 32'(halt_stat_o), 0);
        send_run(JOIN); @(negedge clk);
        check("R12 rejoin", 32'(on_bus_o), 1);
        // R10 reset beats pending halt, R11 set beats clear
        write_ctl(0, 1);
        irq_clr = 1;
        write_ctl(1, 1);
        check("R10 halt dropped", 32'(halt_req_o), 0);
        check("R2 tx cleared", 32'(tx_pend_o), 0);
        repeat (INIT_CYC) @(negedge clk);
        check("R11 set beats clear", 32'(mode_irq_o), 1);
        irq_clr = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule